// File: doc/BRIEF.md
# Nonvolatile Write Status Responder

This block is the device-side control of a byte-wide nonvolatile memory that tells the host whether an internal write is still in progress. The host loads a byte by holding chip enable and write enable low with output enable high. When write enable or chip enable rises to end that load, an internal write cycle of fixed length starts. A counter of `WRITE_CYCLES` clock cycles stands in for the real programming time. When the cycle ends, the byte is committed to a small register-file array.

While the write cycle runs, reads return status and not array data. Bit 7 is the inverse of bit 7 of the byte being written, so a host that polls it sees the true value again once the write has finished. Bit 6 changes value on every read cycle, so a host that compares two reads in a row sees it stop changing when the write is done. The remaining bits either carry the stored byte or are zero, chosen by `OTHER_ZERO`. All bus signals are sampled on the rising clock edge. Read data is registered.

Top module: `nv_write_status`

## Requirements
- R1: After reset busy_o is 0, rdata_o is 0 and every array location reads as 0.
- R2: A load is a sampled cycle with ce_n_i=0, we_n_i=0 and oe_n_i=1 while not busy, and it captures addr_i and wdata_i. The first following sampled cycle with we_n_i=1 or ce_n_i=1 starts the write, and busy_o is 1 from the clock edge that samples it.
- R3: busy_o stays 1 for exactly WRITE_CYCLES consecutive clock cycles per write.
- R4: A cycle with oe_n_i=0 is never a load, so ce_n_i and we_n_i going low and then high while oe_n_i is low starts no write.
- R5: A read is a sampled cycle with ce_n_i=0, oe_n_i=0 and we_n_i=1. rdata_o shows its result one clock later and is 0 after any cycle that is not a read.
- R6: A read while busy returns in bit 7 the inverse of bit 7 of the byte being written, whatever the address.
- R7: Reads while busy return bit 6 as 1 on the first read after the write starts, and inverted on each later read cycle.
- R8: After busy_o falls, the written address reads back the loaded byte in full on every read, so bit 6 no longer changes.
- R9: A load attempted while busy is ignored: it neither restarts nor extends the cycle and never reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Byte to load |
| rdata_o | output | 8 | Registered read data or status |
| busy_o | output | 1 | Internal write cycle running |

## Verification
The hardest case to reach is a run of back-to-back reads that falls wholly inside one write cycle, followed by a load attempt in the same window. That load must leave both the cycle length and the array alone. The stimulus holds chip enable and output enable low across four clock cycles right after a write starts, so the bit-6 sequence 1,0,1,0 and the inverted bit 7 are both seen. It then drives a full load to a different address before busy falls. It measures the whole busy window and reads both addresses afterwards. A second write ends its load on chip enable instead of write enable and polls a byte whose bit 7 is 0.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int DATA_W   = 8;
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TGL_BIT  = DATA_W - 2;

  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LOAD = 2'd1,
    OP_READ = 2'd2
  } bus_op_e;
endpackage

// File: rtl/nvs_bus_decode.sv
module nvs_bus_decode
  import nvs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ce_n_i,
  input  logic    we_n_i,
  input  logic    oe_n_i,
  input  logic    busy_i,
  output bus_op_e op_o,
  output logic    start_o
);
  logic load_q;

  always_comb begin
    op_o = OP_IDLE;
    if (!ce_n_i && !we_n_i && oe_n_i && !busy_i) op_o = OP_LOAD;
    else if (!ce_n_i && !oe_n_i && we_n_i)       op_o = OP_READ;
  end

  // load ends on whichever enable rises first
  assign start_o = load_q && (we_n_i || ce_n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= (op_o == OP_LOAD);
  end
endmodule

// File: rtl/nvs_write_timer.sv
module nvs_write_timer #(
  parameter int WRITE_CYCLES = 20,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i && !busy_o)    cnt_q <= CNT_W'(WRITE_CYCLES);
    else if (busy_o)                cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/nvs_array.sv
module nvs_array
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  byte_t             wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output byte_t             rdata_o
);
  byte_t mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[i] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(i)))      mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nvs_status_mux.sv
module nvs_status_mux
  import nvs_pkg::*;
#(
  parameter bit OTHER_ZERO = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  rd_i,
  input  logic  busy_i,
  input  byte_t last_i,
  input  byte_t array_i,
  output byte_t rdata_o
);
  logic  tgl_q;
  byte_t status;
  byte_t rdata_q;

  always_comb begin
    status           = OTHER_ZERO ? '0 : last_i;
    status[POLL_BIT] = ~last_i[POLL_BIT];
    status[TGL_BIT]  = tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tgl_q <= 1'b1;
    else if (start_i)           tgl_q <= 1'b1;
    else if (rd_i && busy_i)    tgl_q <= ~tgl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_i)  rdata_q <= busy_i ? status : array_i;
    else            rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/nv_write_status.sv
module nv_write_status
  import nvs_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int WRITE_CYCLES = 20,
  parameter bit OTHER_ZERO   = 1'b0,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  bus_op_e           op;
  logic              start, busy, commit, rd_stb;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] last_addr_q;
  byte_t             last_data_q;
  byte_t             array_rd;

  nvs_bus_decode u_dec (
    .clk_i, .rst_ni, .ce_n_i, .we_n_i, .oe_n_i,
    .busy_i (busy),
    .op_o   (op),
    .start_o(start)
  );

  assign rd_stb = (op == OP_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      last_data_q <= '0;
    end else if (op == OP_LOAD) begin
      last_addr_q <= addr_i;
      last_data_q <= wdata_i;
    end
  end

  nvs_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_tmr (
    .clk_i, .rst_ni,
    .start_i (start),
    .busy_o  (busy),
    .commit_o(commit),
    .cnt_o   (cnt)
  );

  nvs_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk_i, .rst_ni,
    .we_i   (commit),
    .waddr_i(last_addr_q),
    .wdata_i(last_data_q),
    .raddr_i(addr_i),
    .rdata_o(array_rd)
  );

  nvs_status_mux #(.OTHER_ZERO(OTHER_ZERO)) u_mux (
    .clk_i, .rst_ni,
    .start_i(start && !busy),
    .rd_i   (rd_stb),
    .busy_i (busy),
    .last_i (last_data_q),
    .array_i(array_rd),
    .rdata_o(rdata_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/nv_write_status_chk.sv
module nv_write_status_chk #(
  parameter int WRITE_CYCLES = 20,
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_n_i,
  input logic             we_n_i,
  input logic             oe_n_i,
  input logic             busy_o,
  input logic [7:0]       rdata_o,
  input logic             rd_stb,
  input logic [7:0]       last_data_q,
  input logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + CNT_W'(1);
    else             run_q <= '0;
  end

  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == CNT_W'(WRITE_CYCLES));

  p_no_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> cnt == $past(cnt) - CNT_W'(1));

  p_start_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(we_n_i || ce_n_i));

  p_poll_inv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_stb && busy_o) |-> rdata_o[7] == ~$past(last_data_q[7]));

  p_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_stb && busy_o) && $past(rd_stb && busy_o, 2))
      |-> rdata_o[6] != $past(rdata_o[6]));

  p_idle_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(!ce_n_i && !oe_n_i && we_n_i)) |-> rdata_o == 8'h00);
endmodule

bind nv_write_status nv_write_status_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk_i, .rst_ni, .ce_n_i, .we_n_i, .oe_n_i, .busy_o, .rdata_o,
  .rd_stb, .last_data_q, .cnt
);

// File: tb/nv_write_status_test.sv
module nv_write_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;

  int errors = 0;
  int checks = 0;
  int busy_cnt = 0;
  logic rd_seen = 1'b0;
  logic tgl_m = 1'b1;

  logic [7:0] exp_q[$];
  logic [7:0] mask_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nv_write_status #(.ADDR_W(4), .WRITE_CYCLES(N), .OTHER_ZERO(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: read sampled at posedge, data compared at the following negedge
  always @(posedge clk) rd_seen <= rst_n && !ce_n && !oe_n && we_n;
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (rd_seen && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic logic [7:0] m = mask_q.pop_front();
      automatic string t = tag_q.pop_front();
      check((rdata & m) == (e & m), t, int'(rdata & m), int'(e & m));
    end
  end

  task automatic idle();
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input logic [7:0] m, input string t);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(t);
  endtask

  // status read during busy: only bits 7 and 6 are compared
  task automatic rd_busy(input logic [3:0] a, input logic [7:0] last, input string t);
    rd(a, {~last[7], tgl_m, 6'h00}, 8'hC0, t);
    tgl_m = ~tgl_m;
  endtask

  task automatic load(input logic [3:0] a, input logic [7:0] d, input bit end_ce);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    @(negedge clk); if (end_ce) ce_n = 1'b1; else we_n = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(rdata == 8'h00, "R1 rdata after reset", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // idle read of a never-written location
    rd(4'd3, 8'h00, 8'hFF, "R1 array zero");
    idle();
    @(negedge clk);
    check(rdata == 8'h00, "R5 no read gives zero", rdata, 0);

    // write 0xA5 at 3, ended by write enable
    busy_cnt = 0; tgl_m = 1'b1;
    load(4'd3, 8'hA5, 1'b0);
    idle();
    check(busy == 1'b1, "R2 busy after we rise", busy, 1);
    rd_busy(4'd3, 8'hA5, "R6 R7 read1");
    rd_busy(4'd3, 8'hA5, "R6 R7 read2");
    rd_busy(4'd9, 8'hA5, "R6 R7 read3 other addr");
    rd_busy(4'd3, 8'hA5, "R6 R7 read4");
    idle();
    // R9: load attempt while busy
    load(4'd5, 8'h3C, 1'b0);
    idle();
    wait_idle();
    check(busy_cnt == N, "R3 R9 busy length", busy_cnt, N);
    rd(4'd3, 8'hA5, 8'hFF, "R8 true data first");
    rd(4'd3, 8'hA5, 8'hFF, "R8 true data second");
    rd(4'd5, 8'h00, 8'hFF, "R9 ignored load not stored");
    idle();
    @(negedge clk);

    // R4: oe low inhibits the load
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 4'd7; wdata = 8'h11;
    @(negedge clk); we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(busy == 1'b0, "R4 no write when oe low", busy, 0);
    end
    rd(4'd7, 8'h00, 8'hFF, "R4 location unchanged");
    idle();

    // write 0x42 at 7, ended by chip enable
    @(negedge clk);
    busy_cnt = 0; tgl_m = 1'b1;
    load(4'd7, 8'h42, 1'b1);
    idle();
    check(busy == 1'b1, "R2 busy after ce rise", busy, 1);
    rd_busy(4'd7, 8'h42, "R6 R7 second write read1");
    idle();
    rd_busy(4'd7, 8'h42, "R6 R7 second write read2");
    idle();
    wait_idle();
    check(busy_cnt == N, "R3 second busy length", busy_cnt, N);
    rd(4'd7, 8'h42, 8'hFF, "R8 second write data");
    rd(4'd3, 8'hA5, 8'hFF, "R8 first write kept");
    idle();
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule